// File: doc/BRIEF.md
# Match-Compare Timer

This block is a memory-mapped up-counting timer with a programmable prescaler and a single compare channel. Software reads the counter at any moment as a free-running time base, or programs the compare value together with a set of match actions to generate single events or a regular tick. The level interrupt output follows a sticky match flag that software clears by writing a one to it.

Register access uses a plain synchronous bus: an address, a write strobe, write data and registered read data. Read data appears one clock after the address is presented and shows the register contents as they were before that clock edge. The counter is clocked only in timer mode, which is mode value 0. The other mode values would count edges from an external source, and this block has no such input.

Top module: `match_timer`

## Requirements
- R1: After synchronous reset, every register reads 0, the interrupt output is 0 and the read data is 0.
- R2: Control register (offset 0x004): bit 0 enables counting and bit 1 holds the counter and the prescale stage at 0. While bit 1 is set the counter reads 0, whatever else happens.
- R3: With counting enabled and mode 0, the counter advances once every P+1 clocks, where P is the prescale register (offset 0x00C). P=0 means the counter advances on every clock.
- R4: When the enable bit is 0, or the mode register (offset 0x070, 2 bits) is non-zero, the counter holds its value.
- R5: A match occurs on a counting tick where the counter equals the compare value (offset 0x018). If match-control bit 0 is set, the flag (interrupt register offset 0x000, bit 0) is set in that cycle, and the interrupt output equals the flag.
- R6: When match-control bit 1 is set, a match loads 0 into the counter instead of incrementing it, so matches recur every (M+1)*(P+1) clocks.
- R7: When match-control bit 2 is set, a match clears the control enable bit in the same cycle. If bit 1 is clear, the counter then holds the compare value; if bit 1 is set, the counter holds 0.
- R8: Writing 1 to bit 0 of the interrupt register clears the flag and writing 0 leaves it unchanged. A match that sets the flag in the same cycle takes priority over the clear.
- R9: Register map: flag 0x000 (1 bit), control 0x004 (2 bits), counter 0x008 (32 bits, writable), prescale 0x00C (32 bits), match control 0x014 (3 bits), compare 0x018 (32 bits), mode 0x070 (2 bits). Unused upper bits read 0, and read data is valid one clock after the address.
- R10: Reads of any other offset return 0, and writes to any other offset change no register.
- R11: A bus write to the counter takes priority over a counting tick, and a bus write to the control register takes priority over a stop-on-match in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, high while the match flag is set |

## Verification
The hardest cases to reach are the collisions in one clock cycle: a match that coincides with a software clear of the flag, with a control write, or with a direct counter write. These resolve by the priorities stated in R8 and R11. A long random phase uses small compare and prescale values and mixes all register writes with idle gaps, so these coincidences happen many times. A cycle-accurate reference model in the bench predicts the flag and the read data on every cycle. Directed sequences then pin down the one-shot, stop-without-wrap and periodic timing, including the exact number of clocks between matches.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  localparam int DATA_W = 32;
  localparam int MODE_W = 2;
  // byte offsets of the registers
  localparam int OFS_FLAG  = 'h000;
  localparam int OFS_CTRL  = 'h004;
  localparam int OFS_COUNT = 'h008;
  localparam int OFS_PRE   = 'h00C;
  localparam int OFS_ACT   = 'h014;
  localparam int OFS_CMP   = 'h018;
  localparam int OFS_MODE  = 'h070;

  // match actions: bit2 stop, bit1 wrap to zero, bit0 raise flag
  typedef struct packed {
    logic stop;
    logic wrap;
    logic intr;
  } match_act_t;
endpackage

// File: rtl/mtmr_prescale.sv
module mtmr_prescale #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] pcnt;

  // a limit lowered below the running count still ends the period at once
  assign tick = run && (pcnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || clr)      pcnt <= '0;
    else if (tick)       pcnt <= '0;
    else if (run)        pcnt <= pcnt + 1'b1;
  end

  assert_pre_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(pcnt));
  assert_pre_clear_R2: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pcnt == '0));
endmodule

// File: rtl/mtmr_count.sv
module mtmr_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] cmp_val,
  input  logic         wrap,
  input  logic         stop,
  output logic [W-1:0] cnt,
  output logic         hit
);
  assign hit = tick && (cnt == cmp_val);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (ld)     cnt <= ld_val;
    else if (hit) begin
      if (wrap)      cnt <= '0;
      else if (!stop) cnt <= cnt + 1'b1;
    end
    else if (tick)   cnt <= cnt + 1'b1;
  end

  assert_clr_zero_R2: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!clr && !tick && !ld) |=> $stable(cnt));
  assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (hit && wrap && !clr && !ld) |=> (cnt == '0));
  assert_stop_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (hit && stop && !wrap && !clr && !ld) |=> $stable(cnt));
endmodule

// File: rtl/match_timer.sv
module match_timer #(
  parameter int ADDR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_we,
  input  logic [mtmr_pkg::DATA_W-1:0] bus_wdata,
  output logic [mtmr_pkg::DATA_W-1:0] bus_rdata,
  output logic                       irq
);
  import mtmr_pkg::*;
  localparam int DW = DATA_W;

  logic                 en_q, hold_q, flag_q;
  logic [DW-1:0]        pre_q, cmp_q, cnt;
  logic [MODE_W-1:0]    mode_q;
  match_act_t           act_q;
  logic                 run, tick, hit;
  logic                 wr_flag, wr_ctrl, wr_cnt, wr_pre, wr_act, wr_cmp, wr_mode;
  logic [DW-1:0]        rd_mux;
  logic                 mapped;

  assign wr_flag = bus_we && (bus_addr == ADDR_W'(OFS_FLAG));
  assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_cnt  = bus_we && (bus_addr == ADDR_W'(OFS_COUNT));
  assign wr_pre  = bus_we && (bus_addr == ADDR_W'(OFS_PRE));
  assign wr_act  = bus_we && (bus_addr == ADDR_W'(OFS_ACT));
  assign wr_cmp  = bus_we && (bus_addr == ADDR_W'(OFS_CMP));
  assign wr_mode = bus_we && (bus_addr == ADDR_W'(OFS_MODE));

  assign run = en_q && !hold_q && (mode_q == '0);

  mtmr_prescale #(.W(DW)) u_pre (
    .clk(clk), .rst(rst), .clr(hold_q), .run(run), .limit(pre_q), .tick(tick)
  );

  mtmr_count #(.W(DW)) u_cnt (
    .clk(clk), .rst(rst), .clr(hold_q), .tick(tick), .ld(wr_cnt),
    .ld_val(bus_wdata), .cmp_val(cmp_q), .wrap(act_q.wrap), .stop(act_q.stop),
    .cnt(cnt), .hit(hit)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      hold_q <= 1'b0;
      pre_q  <= '0;
      act_q  <= '0;
      cmp_q  <= '0;
      mode_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= bus_wdata[0];
        hold_q <= bus_wdata[1];
      end else if (hit && act_q.stop) begin
        en_q   <= 1'b0;
      end
      if (wr_pre)  pre_q  <= bus_wdata;
      if (wr_act)  act_q  <= match_act_t'(bus_wdata[2:0]);
      if (wr_cmp)  cmp_q  <= bus_wdata;
      if (wr_mode) mode_q <= bus_wdata[MODE_W-1:0];
    end
  end

  // sticky match flag, set beats clear
  always_ff @(posedge clk) begin
    if (rst)                         flag_q <= 1'b0;
    else if (hit && act_q.intr)      flag_q <= 1'b1;
    else if (wr_flag && bus_wdata[0]) flag_q <= 1'b0;
  end

  assign irq = flag_q;

  always_comb begin
    rd_mux = '0;
    mapped = 1'b1;
    case (bus_addr)
      ADDR_W'(OFS_FLAG):  rd_mux[0]          = flag_q;
      ADDR_W'(OFS_CTRL):  rd_mux[1:0]        = {hold_q, en_q};
      ADDR_W'(OFS_COUNT): rd_mux             = cnt;
      ADDR_W'(OFS_PRE):   rd_mux             = pre_q;
      ADDR_W'(OFS_ACT):   rd_mux[2:0]        = act_q;
      ADDR_W'(OFS_CMP):   rd_mux             = cmp_q;
      ADDR_W'(OFS_MODE):  rd_mux[MODE_W-1:0] = mode_q;
      default:            mapped             = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  assert_stop_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (hit && act_q.stop && !wr_ctrl) |=> !en_q);
  assert_flag_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(act_q.intr && tick));
  assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_flag && bus_wdata[0] && !(hit && act_q.intr)) |=> !irq);
  assert_unmapped_R10: assert property (@(posedge clk) disable iff (rst)
    !mapped |=> (bus_rdata == '0));
endmodule

// File: tb/test_match_timer.sv
module test_match_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int nchk = 0;
  int nfail = 0;
  int ncyc = 0;

  always #10 clk = ~clk;  // 50 MHz

  match_timer #(.ADDR_W(8)) i_match_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // reference model state
  logic        m_en = 0, m_hold = 0, m_flag = 0;
  logic [31:0] m_pre = 0, m_pc = 0, m_tc = 0, m_cmp = 0, m_rd = 0;
  logic [2:0]  m_act = 0;
  logic [1:0]  m_mode = 0;

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00: return {31'd0, m_flag};
      8'h04: return {30'd0, m_hold, m_en};
      8'h08: return m_tc;
      8'h0C: return m_pre;
      8'h14: return {29'd0, m_act};
      8'h18: return m_cmp;
      8'h70: return {30'd0, m_mode};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: advance the model, then compare at the falling edge
  task automatic cyc();
    logic run, tick, hit, w;
    logic        en_n, hold_n, flag_n;
    logic [31:0] pc_n, tc_n, pre_n, cmp_n, rd_n;
    logic [2:0]  act_n;
    logic [1:0]  mode_n;
    run  = m_en && !m_hold && (m_mode == 0);
    tick = run && (m_pc >= m_pre);
    hit  = tick && (m_tc == m_cmp);
    w    = bus_we;
    pc_n = m_hold ? 0 : tick ? 0 : run ? m_pc + 1 : m_pc;
    if (m_hold) tc_n = 0;
    else if (w && bus_addr == 8'h08) tc_n = bus_wdata;
    else if (hit) tc_n = m_act[1] ? 0 : (m_act[2] ? m_tc : m_tc + 1);
    else if (tick) tc_n = m_tc + 1;
    else tc_n = m_tc;
    en_n = m_en; hold_n = m_hold;
    if (w && bus_addr == 8'h04) begin en_n = bus_wdata[0]; hold_n = bus_wdata[1]; end
    else if (hit && m_act[2]) en_n = 0;
    flag_n = (hit && m_act[0]) ? 1'b1 : (w && bus_addr == 8'h00 && bus_wdata[0]) ? 1'b0 : m_flag;
    pre_n  = (w && bus_addr == 8'h0C) ? bus_wdata : m_pre;
    act_n  = (w && bus_addr == 8'h14) ? bus_wdata[2:0] : m_act;
    cmp_n  = (w && bus_addr == 8'h18) ? bus_wdata : m_cmp;
    mode_n = (w && bus_addr == 8'h70) ? bus_wdata[1:0] : m_mode;
    rd_n   = model_read(bus_addr);
    if (rst) begin
      pc_n = 0; tc_n = 0; en_n = 0; hold_n = 0; flag_n = 0; pre_n = 0;
      act_n = 0; cmp_n = 0; mode_n = 0; rd_n = 0;
    end
    @(posedge clk);
    m_pc = pc_n; m_tc = tc_n; m_en = en_n; m_hold = hold_n; m_flag = flag_n;
    m_pre = pre_n; m_act = act_n; m_cmp = cmp_n; m_mode = mode_n; m_rd = rd_n;
    @(negedge clk);
    chk("R5 irq vs model", {31'd0, irq}, {31'd0, m_flag});
    chk("R9 rdata vs model", bus_rdata, m_rd);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    cyc();
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    cyc();
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  always @(posedge clk) begin
    ncyc++;
    if (ncyc == 150000) begin
      nfail++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int n;
    void'($urandom(32'd20240517));
    rst = 1'b1;
    idle(3);
    rst = 1'b0;

    // R1: reset state
    rd(8'h00, v); chk("R1 flag", v, 0);
    rd(8'h04, v); chk("R1 ctrl", v, 0);
    rd(8'h08, v); chk("R1 count", v, 0);
    rd(8'h14, v); chk("R1 act", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R9: field widths and readback
    wr(8'h0C, 32'h0000_00A5); rd(8'h0C, v); chk("R9 prescale", v, 32'hA5);
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, v); chk("R9 act width", v, 7);
    wr(8'h70, 32'hFFFF_FFFF); rd(8'h70, v); chk("R9 mode width", v, 3);
    wr(8'h70, 0); wr(8'h0C, 0);

    // R10: unmapped offsets
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, v); chk("R10 unmapped read", v, 0);
    rd(8'h1C, v); chk("R10 unmapped read 1C", v, 0);
    rd(8'h18, v); chk("R10 no side effect", v, 0);

    // R11: counter load
    wr(8'h08, 32'h0000_1234); rd(8'h08, v); chk("R11 counter write", v, 32'h1234);

    // R2: hold in reset
    wr(8'h04, 3); idle(4); rd(8'h08, v); chk("R2 held zero", v, 0);

    // R7 + R5: one-shot with wrap
    wr(8'h14, 7); wr(8'h18, 5); wr(8'h04, 2); wr(8'h04, 1);
    idle(10);
    rd(8'h04, v); chk("R7 enable cleared", v, 0);
    rd(8'h08, v); chk("R7 wrapped to zero", v, 0);
    chk("R5 irq raised", {31'd0, irq}, 1);

    // R8: write-one-to-clear
    wr(8'h00, 0); chk("R8 write zero keeps", {31'd0, irq}, 1);
    wr(8'h00, 1); chk("R8 write one clears", {31'd0, irq}, 0);

    // R7: stop without wrap holds compare value
    wr(8'h14, 5); wr(8'h18, 4); wr(8'h04, 2); wr(8'h04, 1);
    idle(10);
    rd(8'h08, v); chk("R7 holds compare", v, 4);
    wr(8'h00, 1);

    // R6 + R3: periodic with prescale 1, compare 3 -> every 8 clocks
    wr(8'h14, 3); wr(8'h0C, 1); wr(8'h18, 3); wr(8'h04, 2);
    wr(8'h04, 1);
    n = 0;
    while (!irq && n < 50) begin cyc(); n++; end
    chk("R3 first match delay", n, 8);
    wr(8'h00, 1);
    n = 0;
    while (!irq && n < 50) begin cyc(); n++; end
    chk("R6 match period", n, 7);

    // R4: disable and non-zero mode hold the counter
    wr(8'h04, 0); rd(8'h08, v); idle(5); rd(8'h08, v2); chk("R4 disabled hold", v2, v);
    wr(8'h70, 1); wr(8'h04, 1); rd(8'h08, v); idle(5); rd(8'h08, v2); chk("R4 mode hold", v2, v);
    wr(8'h70, 0);

    // random phase: collisions of matches with R8 and R11 writes
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom % 10;
      case (op)
        0: wr(8'h04, (($urandom % 4) == 0) ? ($urandom % 4) : 1);
        1: wr(8'h0C, $urandom % 4);
        2: wr(8'h14, $urandom % 8);
        3: wr(8'h18, $urandom % 24);
        4: wr(8'h70, (($urandom % 5) == 0) ? 1 : 0);
        5: wr(8'h00, $urandom % 2);
        6: wr(8'h08, $urandom % 20);
        7: wr(8'((($urandom) % 32) * 4), $urandom);
        default: rd(8'((($urandom) % 32) * 4), v);
      endcase
      idle($urandom % 3);
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule